// File: doc/BRIEF.md
# Transmit Byte Buffer with Byte and Word Push Ports

This block holds the bytes waiting to be shifted out by a serial engine. Software writes either one byte at a time through a byte address or four bytes at once through a word address. Both go into the same byte-wide circular buffer. The serial engine takes bytes one at a time from a pop port. The block reports the number of unused byte slots in the upper half of a 32-bit transfer status word.

Three sticky event flags feed an interrupt status register: the buffer draining to empty, the buffer filling up, and a push that did not fit. Software clears a flag by writing a 1 to it. The block drives one interrupt request line whenever a set flag is also enabled. The empty event is the signal to refill the buffer. When a word arrives and fewer than four slots are free, the whole word is discarded.

Top module: `tfifo_top`

## Requirements
- R1: A push with `wr_word`=0 stores `wr_data[7:0]` as one byte and ignores the upper bits.
- R2: A push with `wr_word`=1 stores four bytes. `wr_data[7:0]` is popped first and `wr_data[31:24]` last.
- R3: `xfer_status[31:16]` equals DEPTH minus the number of stored bytes, and `xfer_status[15:0]` is zero. After reset it reads DEPTH (64).
- R4: `pop_valid` is high whenever at least one byte is stored, and `pop_data` shows the oldest byte. A `pop_req` in that state removes the byte at the next edge. A `pop_req` while empty has no effect.
- R5: `int_flags[0]` (empty) is set only when the occupancy goes from nonzero to zero. Reset alone does not set it.
- R6: `int_flags[1]` (full) is set only when the occupancy goes from below DEPTH to DEPTH.
- R7: `int_flags[2]` (overrun) is set when a byte push finds no free slot, or when a word push finds fewer than four free slots. The rejected data is dropped whole and the stored contents are unchanged.
- R8: A cycle with `clr_wr` high clears every flag whose `clr_mask` bit is 1 and leaves the other flags alone. A flag that is set in the same cycle stays set.
- R9: `irq` is high exactly when some bit of `int_flags` is set and its `irq_en` bit is 1.
- R10: When a push and a pop happen in the same cycle, the push is accepted or rejected based on the occupancy before that cycle. The new occupancy is the old occupancy plus the bytes pushed minus the byte popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push strobe from the register write port |
| wr_word | input | 1 | 1 = word address (four bytes), 0 = byte address |
| wr_data | input | 32 | Write data |
| pop_req | input | 1 | Engine takes the head byte |
| pop_valid | output | 1 | At least one byte is stored |
| pop_data | output | 8 | Oldest stored byte |
| xfer_status | output | 32 | Free byte count in bits 31:16, zero below |
| clr_wr | input | 1 | Write strobe for the interrupt status register |
| clr_mask | input | 3 | Write-1-to-clear mask: bit0 empty, bit1 full, bit2 overrun |
| irq_en | input | 3 | Interrupt enables, same bit order as the flags |
| int_flags | output | 3 | Sticky flags: bit0 empty, bit1 full, bit2 overrun |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are at the boundary between full and empty, where a pop in the same cycle could change whether a push is accepted. The bench first fills the buffer with sixteen word pushes. It then pushes a byte and pops in the same cycle, and later pushes a word with exactly four slots free while popping. These two cases show that acceptance is judged on the occupancy at the start of the cycle.

A word rejected with only one slot free, followed by a byte accepted into that slot, separates the two acceptance thresholds. The bench then drains all 64 bytes to confirm that no rejected data leaked into storage and that the pointers wrapped correctly.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
    localparam int FLG_EMPTY = 0;
    localparam int FLG_FULL  = 1;
    localparam int FLG_OVR   = 2;
    localparam int NFLG      = 3;
endpackage

// File: rtl/tfifo_store.sv
module tfifo_store #(
    parameter int DEPTH = 64,
    parameter int LANES = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1,
    localparam int PW = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    push_cnt,
    input  logic [8*LANES-1:0] push_data,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [CW-1:0]    occ_q,
    output logic [CW-1:0]    occ_d
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] occ;
    } st_t;

    st_t st_d, st_q;
    logic [7:0] mem [DEPTH];

    always_comb begin
        st_d     = st_q;
        st_d.wp  = st_q.wp + AW'(push_cnt);
        st_d.rp  = st_q.rp + AW'(pop);
        st_d.occ = st_q.occ + CW'(push_cnt) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(push_cnt))
                mem[st_q.wp + AW'(k)] <= push_data[8*k +: 8];
        end
    end

    assign head  = (st_q.occ != '0) ? mem[st_q.rp] : 8'h00;
    assign occ_q = st_q.occ;
    assign occ_d = st_d.occ;
endmodule

// File: rtl/tfifo_flags.sv
module tfifo_flags
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   occ_q,
    input  logic [CW-1:0]   occ_d,
    input  logic            ovr_evt,
    input  logic            clr_wr,
    input  logic [NFLG-1:0] clr_mask,
    input  logic [NFLG-1:0] en,
    output logic [NFLG-1:0] flags,
    output logic            irq
);
    typedef struct packed {
        logic [NFLG-1:0] flg;
    } st_t;

    st_t st_d, st_q;
    logic [NFLG-1:0] set_v;

    always_comb begin
        set_v            = '0;
        set_v[FLG_EMPTY] = (occ_q != '0) && (occ_d == '0);
        set_v[FLG_FULL]  = (occ_q != CW'(DEPTH)) && (occ_d == CW'(DEPTH));
        set_v[FLG_OVR]   = ovr_evt;
        st_d.flg = (st_q.flg & ~(clr_wr ? clr_mask : '0)) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flg;
    assign irq   = |(st_q.flg & en);
endmodule

// File: rtl/tfifo_top.sv
module tfifo_top
    import tfifo_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int CW    = $clog2(DEPTH) + 1,
    localparam int PW    = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop_req,
    output logic              pop_valid,
    output logic [7:0]        pop_data,
    output logic [31:0]       xfer_status,
    input  logic              clr_wr,
    input  logic [NFLG-1:0]   clr_mask,
    input  logic [NFLG-1:0]   irq_en,
    output logic [NFLG-1:0]   int_flags,
    output logic              irq
);
    logic [CW-1:0] occ_q, occ_d, free;
    logic          accept, ovr_evt, pop_fire;
    logic [PW-1:0] push_cnt;

    always_comb begin
        free     = CW'(DEPTH) - occ_q;
        accept   = wr_word ? (free >= CW'(LANES)) : (free != '0);
        push_cnt = (wr_en && accept) ? (wr_word ? PW'(LANES) : PW'(1)) : '0;
        ovr_evt  = wr_en && !accept;
        pop_fire = pop_req && (occ_q != '0);
    end

    tfifo_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
        .clk(clk), .rst_n(rst_n), .push_cnt(push_cnt), .push_data(wr_data),
        .pop(pop_fire), .head(pop_data), .occ_q(occ_q), .occ_d(occ_d)
    );

    tfifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .occ_q(occ_q), .occ_d(occ_d), .ovr_evt(ovr_evt),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .en(irq_en), .flags(int_flags), .irq(irq)
    );

    assign pop_valid   = (occ_q != '0);
    assign xfer_status = {{(16-CW){1'b0}}, free, 16'h0000};
endmodule

// File: rtl/tfifo_chk.sv
module tfifo_chk #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_word,
    input logic        pop_req,
    input logic        pop_valid,
    input logic [31:0] xfer_status,
    input logic        clr_wr,
    input logic [2:0]  clr_mask,
    input logic [2:0]  int_flags
);
    logic [15:0] free;
    logic        ovr;
    assign free = xfer_status[31:16];
    assign ovr  = wr_en && (wr_word ? (free < 16'd4) : (free == 16'd0));

    // R3
    free_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free <= 16'(DEPTH) && xfer_status[15:0] == 16'h0);
    // R7
    word_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_word && free < 16'd4 |=> int_flags[2]);
    // R7
    byte_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_word && free == 16'd0 && !pop_req |=> $stable(xfer_status));
    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !pop_valid && !wr_en |=> $stable(xfer_status));
    // R5
    empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_flags[0]) |-> free == 16'(DEPTH));
    // R6
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_flags[1]) |-> free == 16'd0);
    // R8
    ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && clr_mask[2] && !ovr |=> !int_flags[2]);
endmodule

bind tfifo_top tfifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .pop_req(pop_req),
    .pop_valid(pop_valid), .xfer_status(xfer_status), .clr_wr(clr_wr),
    .clr_mask(clr_mask), .int_flags(int_flags)
);

// File: tb/tfifo_top_test.sv
module tfifo_top_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, wr_word = 0, pop_req = 0, clr_wr = 0;
    logic [31:0] wr_data = '0;
    logic [2:0]  clr_mask = '0, irq_en = '0;
    logic        pop_valid, irq;
    logic [7:0]  pop_data;
    logic [31:0] xfer_status;
    logic [2:0]  int_flags;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tfifo_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
        .xfer_status(xfer_status), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .irq_en(irq_en), .int_flags(int_flags), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] free_of();
        return xfer_status[31:16];
    endfunction

    task automatic push_b(input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_word = 0; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic push_w(input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_word = 1; wr_data = d;
        @(negedge clk); wr_en = 0; wr_word = 0;
    endtask

    task automatic pop_b(output logic [7:0] b);
        @(negedge clk); b = pop_data; pop_req = 1;
        @(negedge clk); pop_req = 0;
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk); clr_wr = 1; clr_mask = m;
        @(negedge clk); clr_wr = 0; clr_mask = '0;
    endtask

    task automatic fill16();
        for (int i = 0; i < 16; i++)
            push_w({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R3 reset free", 32'(free_of()), 32'd64);
        chk("R3 low half", 32'(xfer_status[15:0]), 32'd0);
        chk("R5 no flag at reset", 32'(int_flags), 32'd0);
        chk("R4 reset valid", 32'(pop_valid), 32'd0);
    endtask

    task automatic t_byte();
        logic [7:0] b;
        push_b(32'h123456A5);
        chk("R1 free after byte", 32'(free_of()), 32'd63);
        chk("R4 valid", 32'(pop_valid), 32'd1);
        pop_b(b);
        chk("R1 byte value", 32'(b), 32'hA5);
        chk("R5 empty set", 32'(int_flags), 32'b001);
        clear(3'b001);
        chk("R8 empty cleared", 32'(int_flags), 32'd0);
    endtask

    task automatic t_word();
        logic [7:0] b;
        push_w(32'h44332211);
        chk("R2 free after word", 32'(free_of()), 32'd60);
        for (int k = 0; k < 4; k++) begin
            pop_b(b);
            chk("R2 byte order", 32'(b), 32'(8'h11 * (k + 1)));
        end
        chk("R5 empty after word", 32'(int_flags), 32'b001);
        clear(3'b110);
        chk("R8 zero mask bits kept", 32'(int_flags), 32'b001);
        clear(3'b111);
    endtask

    task automatic t_pop_empty();
        @(negedge clk); pop_req = 1;
        @(negedge clk); pop_req = 0;
        chk("R4 pop empty free", 32'(free_of()), 32'd64);
        chk("R4 pop empty flags", 32'(int_flags), 32'd0);
    endtask

    task automatic t_fill();
        logic [7:0] b;
        fill16();
        chk("R6 free at full", 32'(free_of()), 32'd0);
        chk("R6 full set", 32'(int_flags), 32'b010);
        clear(3'b111);
        push_b(32'hEE);
        chk("R7 byte overrun", 32'(int_flags), 32'b100);
        chk("R7 free unchanged", 32'(free_of()), 32'd0);
        pop_b(b);
        chk("R4 head byte", 32'(b), 32'd0);
        clear(3'b100);
        push_w(32'hDEADBEEF);
        chk("R7 word overrun 1 free", 32'(int_flags), 32'b100);
        chk("R7 word dropped", 32'(free_of()), 32'd1);
        push_b(32'hEE);
        chk("R6 byte into last slot", 32'(free_of()), 32'd0);
        chk("R6 full again", 32'(int_flags), 32'b110);
        clear(3'b111);
        for (int i = 1; i < 64; i++) begin
            pop_b(b);
            chk("R7 drain content", 32'(b), 32'(i));
        end
        pop_b(b);
        chk("R7 drain last", 32'(b), 32'hEE);
        chk("R5 empty after drain", 32'(int_flags), 32'b001);
        clear(3'b111);
    endtask

    task automatic t_irq();
        logic [7:0] b;
        push_b(32'h5);
        pop_b(b);
        irq_en = 3'b110;
        #1 chk("R9 masked", 32'(irq), 32'd0);
        irq_en = 3'b001;
        #1 chk("R9 enabled", 32'(irq), 32'd1);
        clear(3'b001);
        chk("R9 cleared", 32'(irq), 32'd0);
        irq_en = 3'b000;
    endtask

    task automatic t_set_wins();
        push_b(32'h7);
        @(negedge clk); pop_req = 1; clr_wr = 1; clr_mask = 3'b001;
        @(negedge clk); pop_req = 0; clr_wr = 0; clr_mask = '0;
        chk("R8 set beats clear", 32'(int_flags), 32'b001);
        clear(3'b111);
    endtask

    task automatic t_simul();
        logic [7:0] b;
        fill16();
        clear(3'b111);
        @(negedge clk); wr_en = 1; wr_word = 0; wr_data = 32'hAA; pop_req = 1;
        @(negedge clk); wr_en = 0; pop_req = 0;
        chk("R10 byte rejected at full", 32'(int_flags), 32'b100);
        chk("R10 free after pop", 32'(free_of()), 32'd1);
        clear(3'b111);
        for (int i = 0; i < 3; i++) pop_b(b);
        chk("R10 free four", 32'(free_of()), 32'd4);
        @(negedge clk); wr_en = 1; wr_word = 1; wr_data = 32'h01020304; pop_req = 1;
        @(negedge clk); wr_en = 0; wr_word = 0; pop_req = 0;
        chk("R10 word accepted", 32'(int_flags[2]), 32'd0);
        chk("R10 free after both", 32'(free_of()), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_byte();
        t_word();
        t_pop_empty();
        t_fill();
        t_irq();
        t_set_wins();
        t_simul();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule